// File: doc/BRIEF.md
# Synchronized Programmable Divider Pair

This block holds the two programmable counters that feed a phase comparator in a frequency synthesizer. One counter divides the reference clock and the other divides the RF (VCO) clock. Each input arrives as a single-cycle count strobe in the block's clock domain. Each counter emits a one-cycle output pulse once per full division period. Ratios come from programming latches outside the block. A counter only picks up a new ratio at the moment it wraps, so a period that is already running keeps the length it started with. A ratio below the legal floor of its counter is refused, and the counter keeps the last legal value.

The block also turns the hardware power-on pin and the software power-on bit into a synthesizer enable. A polarity select decides which level counts as active for both sources. When the enable goes active, both counters load their ratios in the same cycle and start from a common point, so their first output pulses come out phase-aligned. While disabled, neither counter produces pulses. A reload indicator goes high in every cycle in which either counter is reading its ratio. The programming side uses it to postpone a latch update.

Top module: `synth_div_pair`

## Requirements
- R1: The enable output `synth_en_o` is low out of reset. It is high in a cycle only if, on the previous clock edge, both `pon_i` and `spon_i` were at the active level. If either one was not, it is low.
- R2: The active level equals `pol_i`: with `pol_i`=1 both power-on sources are active high, and with `pol_i`=0 both are active low.
- R3: The reference counter adopts a ratio from 8 to 2047 on `ref_ratio_i`. A value below 8 is refused, and the counter keeps its previous ratio. The out-of-reset ratio is 8.
- R4: The main counter adopts a ratio from 512 to 131071 on `main_ratio_i`. A value below 512 is refused, and the counter keeps its previous ratio. The out-of-reset ratio is 512.
- R5: While enabled, a counter with ratio N raises its edge output for exactly one cycle for every N strobes it counts. The pulse appears in the cycle after the clock edge that takes the Nth strobe.
- R6: A ratio is sampled only at a counter's wrap point, which is the strobe that ends a period, or at turn-on. Changing the ratio input in the middle of a period does not change that period's length.
- R7: On the clock edge where the enable rises, both counters load their ratios together and ignore strobes in that cycle. With strobes every cycle, each counter's first edge appears exactly N cycles after `synth_en_o` goes high, so equal ratios give coincident first edges.
- R8: While `synth_en_o` is low, neither edge output pulses. Re-enabling restarts both counters from the turn-on point.
- R9: `ratio_rd_o` is high, combinationally, in exactly those cycles in which an enabled counter receives a strobe while at its terminal count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_tick_i | input | 1 | Reference input count strobe |
| rf_tick_i | input | 1 | RF input count strobe |
| ref_ratio_i | input | 11 | Latched reference division ratio |
| main_ratio_i | input | 17 | Latched main division ratio |
| pon_i | input | 1 | Hardware power-on input |
| spon_i | input | 1 | Software power-on bit |
| pol_i | input | 1 | Active level of both power-on sources |
| synth_en_o | output | 1 | Synthesizer enable |
| ref_edge_o | output | 1 | Reference divider output pulse |
| main_edge_o | output | 1 | Main divider output pulse |
| ratio_rd_o | output | 1 | A counter is sampling its ratio this cycle |

## Verification
The hardest case to reach is a ratio change that lands strictly inside a running period. The stimulus waits for an output pulse, lets a few strobes pass, and then writes the new ratio. It checks that the period in progress keeps its old length and that the following period has the new length. Coincident first edges are reached by re-enabling with equal reference and main ratios, and refused ratios are written while the counters are already running at a known legal value.

// File: rtl/synth_div_pkg.sv
package synth_div_pkg;
  localparam int REF_W    = 11;
  localparam int MAIN_W   = 17;
  localparam int REF_MIN  = 8;
  localparam int MAIN_MIN = 512;
endpackage

// File: rtl/synth_pwr_ctl.sv
module synth_pwr_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pon_i,
  input  logic spon_i,
  input  logic pol_i,
  output logic en_o,
  output logic start_o
);
  logic want;
  logic en_q;

  assign want = (pon_i == pol_i) && (spon_i == pol_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= want;
  end

  assign en_o    = en_q;
  assign start_o = want & ~en_q;

  p_off_if_pon_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pon_i != pol_i) |=> !en_o);
  p_off_if_spon_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spon_i != pol_i) |=> !en_o);
  p_on_at_pol_level_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pon_i == pol_i && spon_i == pol_i) |=> en_o);
endmodule

// File: rtl/synth_prog_div.sv
module synth_prog_div #(
  parameter int W   = 11,
  parameter int MIN = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         start_i,
  input  logic         tick_i,
  input  logic [W-1:0] ratio_i,
  output logic         edge_o,
  output logic         reload_o
);
  localparam logic [W-1:0] MIN_V = W'(MIN);
  localparam logic [W-1:0] ONE   = W'(1);

  logic [W-1:0] act_q, cnt_q, nxt_ratio;
  logic         edge_q, fire;

  // refused ratios keep the last legal one
  assign nxt_ratio = (ratio_i >= MIN_V) ? ratio_i : act_q;
  assign fire      = en_i & tick_i & (cnt_q == '0);
  assign reload_o  = fire;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= MIN_V;
      cnt_q  <= '0;
      edge_q <= 1'b0;
    end else begin
      edge_q <= fire;
      if (start_i || fire) begin
        act_q <= nxt_ratio;
        cnt_q <= nxt_ratio - ONE;
      end else if (en_i && tick_i) begin
        cnt_q <= cnt_q - ONE;
      end
    end
  end

  assign edge_o = edge_q;

  // R4 for the main instance
  p_ratio_floor_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q >= MIN_V);
  p_cnt_in_period_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < act_q);
  p_reload_at_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(act_q) |-> $past(fire | start_i));
  p_common_start_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (cnt_q == act_q - ONE));
  p_quiet_when_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !edge_o);
endmodule

// File: rtl/synth_div_pair.sv
module synth_div_pair
  import synth_div_pkg::*;
#(
  parameter int RW   = REF_W,
  parameter int MW   = MAIN_W,
  parameter int RMIN = REF_MIN,
  parameter int MMIN = MAIN_MIN
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ref_tick_i,
  input  logic          rf_tick_i,
  input  logic [RW-1:0] ref_ratio_i,
  input  logic [MW-1:0] main_ratio_i,
  input  logic          pon_i,
  input  logic          spon_i,
  input  logic          pol_i,
  output logic          synth_en_o,
  output logic          ref_edge_o,
  output logic          main_edge_o,
  output logic          ratio_rd_o
);
  logic en, start, ref_rd, main_rd;

  synth_pwr_ctl u_pwr (
    .clk_i, .rst_ni, .pon_i, .spon_i, .pol_i,
    .en_o(en), .start_o(start)
  );

  synth_prog_div #(.W(RW), .MIN(RMIN)) u_ref_div (
    .clk_i, .rst_ni, .en_i(en), .start_i(start), .tick_i(ref_tick_i),
    .ratio_i(ref_ratio_i), .edge_o(ref_edge_o), .reload_o(ref_rd)
  );

  synth_prog_div #(.W(MW), .MIN(MMIN)) u_main_div (
    .clk_i, .rst_ni, .en_i(en), .start_i(start), .tick_i(rf_tick_i),
    .ratio_i(main_ratio_i), .edge_o(main_edge_o), .reload_o(main_rd)
  );

  assign synth_en_o = en;
  assign ratio_rd_o = ref_rd | main_rd;

  p_read_then_edge_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ratio_rd_o |=> (ref_edge_o | main_edge_o));
  p_first_edges_need_en_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(synth_en_o) |-> !(ref_edge_o | main_edge_o));
endmodule

// File: tb/synth_div_pair_bench.sv
`timescale 1ns/1ps
module synth_div_pair_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ref_tick = 1'b1, rf_tick = 1'b1;
  logic [10:0] ref_ratio = 11'd10;
  logic [16:0] main_ratio = 17'd600;
  logic pon = 1'b0, spon = 1'b0, pol = 1'b1;
  logic en_o, ref_edge, main_edge, rd_o;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0, rnd_ticks = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  synth_div_pair u_synth_div_pair (
    .clk_i(clk), .rst_ni(rst_n), .ref_tick_i(ref_tick), .rf_tick_i(rf_tick),
    .ref_ratio_i(ref_ratio), .main_ratio_i(main_ratio), .pon_i(pon),
    .spon_i(spon), .pol_i(pol), .synth_en_o(en_o), .ref_edge_o(ref_edge),
    .main_edge_o(main_edge), .ratio_rd_o(rd_o)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural reference model
  bit m_en, m_redge, m_medge;
  int m_rcnt, m_ract, m_mcnt, m_mact;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_redge = 0; m_medge = 0;
      m_rcnt = 0; m_ract = 8; m_mcnt = 0; m_mact = 512;
    end else begin
      bit want, st, rf, mf;
      int rn, mn;
      want = (pon == pol) && (spon == pol);
      st = want && !m_en;
      rf = m_en && ref_tick && m_rcnt == 0;
      mf = m_en && rf_tick && m_mcnt == 0;
      rn = (ref_ratio >= 8) ? int'(ref_ratio) : m_ract;
      mn = (main_ratio >= 512) ? int'(main_ratio) : m_mact;
      if (st || rf) begin m_ract = rn; m_rcnt = rn - 1; end
      else if (m_en && ref_tick) m_rcnt--;
      if (st || mf) begin m_mact = mn; m_mcnt = mn - 1; end
      else if (m_en && rf_tick) m_mcnt--;
      m_redge = rf; m_medge = mf;
      m_en = want;
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    bit exp_rd;
    exp_rd = m_en && ((ref_tick && m_rcnt == 0) || (rf_tick && m_mcnt == 0));
    check("R1 enable", int'(en_o), int'(m_en));
    check("R5 ref edge", int'(ref_edge), int'(m_redge));
    check("R5 main edge", int'(main_edge), int'(m_medge));
    check("R9 ratio read", int'(rd_o), int'(exp_rd));
  end

  always @(negedge clk) if (rnd_ticks) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    ref_tick = lfsr[3];
    rf_tick  = lfsr[7] | lfsr[1];
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 180000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<=180000", cyc);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic step(int k);
    repeat (k) @(negedge clk);
    #1;
  endtask

  function automatic bit sel_edge(bit main);
    return main ? main_edge : ref_edge;
  endfunction

  // cycles between consecutive pulses of one divider
  task automatic period(bit main, output int n);
    n = 0;
    @(negedge clk);
    while (!sel_edge(main)) @(negedge clk);
    do begin @(negedge clk); n++; end while (!sel_edge(main) && n < 4000);
    #1;
  endtask

  // cycles from enable seen high to each first pulse
  task automatic first_edges(output int nr, output int nm);
    int n;
    n = 0; nr = -1; nm = -1;
    @(negedge clk);
    while (!en_o) @(negedge clk);
    while ((nr < 0 || nm < 0) && n < 4000) begin
      @(negedge clk); n++;
      if (ref_edge && nr < 0) nr = n;
      if (main_edge && nm < 0) nm = n;
    end
    #1;
  endtask

  initial begin
    int p, q, n, cnt;
    step(3);
    check("R1 reset enable", int'(en_o), 0);
    check("R8 reset edges", int'(ref_edge | main_edge), 0);
    rst_n = 1'b1;
    step(2);
    pon = 1; spon = 0; step(3);
    check("R1 spon inactive", int'(en_o), 0);
    pon = 0; spon = 1; step(3);
    check("R1 pon inactive", int'(en_o), 0);
    pon = 1;
    first_edges(p, q);
    check("R7 first ref edge", p, 10);
    check("R7 first main edge", q, 600);
    check("R2 active high enable", int'(en_o), 1);
    period(0, p); check("R5 ref period 10", p, 10);
    period(1, p); check("R5 main period 600", p, 600);
    ref_ratio = 8; main_ratio = 512;
    period(0, p); period(0, p); check("R3 ref min 8", p, 8);
    period(1, p); period(1, p); check("R4 main min 512", p, 512);
    ref_ratio = 3; main_ratio = 100;
    period(0, p); period(0, p); check("R3 refused ratio 3", p, 8);
    period(1, p); period(1, p); check("R4 refused ratio 100", p, 512);
    main_ratio = 511;
    period(1, p); period(1, p); check("R4 refused ratio 511", p, 512);
    ref_ratio = 2047;
    period(0, p); period(0, p); check("R3 ref max 2047", p, 2047);
    ref_ratio = 20;
    period(0, p); period(0, p); check("R5 ref period 20", p, 20);
    // R6: change inside a running period
    @(negedge clk); while (!ref_edge) @(negedge clk);
    n = 0;
    repeat (5) begin @(negedge clk); n++; end
    #1; ref_ratio = 9;
    @(negedge clk); n++;
    while (!ref_edge && n < 100) begin @(negedge clk); n++; end
    #1;
    check("R6 running period kept", n, 20);
    period(0, p); check("R6 new ratio next period", p, 9);
    // R8: off means no pulses
    pon = 0; step(2);
    check("R1 off after pon drop", int'(en_o), 0);
    cnt = 0;
    repeat (700) begin @(negedge clk); if (ref_edge | main_edge) cnt++; end
    #1;
    check("R8 no pulses while off", cnt, 0);
    // R2: active low
    pol = 0; pon = 0; spon = 0;
    ref_ratio = 512; main_ratio = 512;
    first_edges(p, q);
    check("R2 active low enable", int'(en_o), 1);
    check("R7 aligned first edges", p, q);
    check("R7 aligned first edge count", p, 512);
    spon = 1; step(2);
    check("R2 active low spon high off", int'(en_o), 0);
    // irregular strobes, model compared every cycle
    spon = 0; ref_ratio = 9; main_ratio = 513;
    rnd_ticks = 1;
    repeat (6) begin
      step(2500);
      pon = ~pon;
      step(40);
      pon = ~pon;
    end
    rnd_ticks = 0;
    step(5);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule